// File: doc/BRIEF.md
# 5x5 Matrix Display Controller

A peripheral for a small processor's device interface. The processor selects one device at a time by number, then sends bytes or a feed (new line) command. This controller stores one 4-bit brightness level for each lamp of a 5 by 5 grid and fills that store line by line, starting from the top line. After the last lamp of the bottom line, it wraps back to the top line.

Each lamp output is refreshed continuously by pulse-width modulation. A free-running counter is compared against the stored level of each lamp. Level 0 keeps a lamp dark and level 15 keeps it lit for 15 of every 16 cycles. Only strobes that arrive while this controller is the selected device have any effect.

Top module: `matrix_display_ctrl`

## Requirements
- R1: After reset, every lamp output stays 0 and the controller is not selected. A write before any select strobe therefore changes no lamp.
- R2: An accepted write stores `wr_data_i[3:0]` as the level of lamp `row*5 + col`, which drives `lamp_o[row*5 + col]`. Bits `wr_data_i[7:4]` have no effect.
- R3: Each accepted write moves the cursor to the next column. A write to column 4 returns the column to 0 and moves to the next row.
- R4: A write to row 4, column 4 returns the cursor to row 0, column 0, so the 26th write after a select lands on lamp 0.
- R5: An accepted feed sets the column to 0 and moves to the next row, going from row 4 back to row 0. When a write and a feed arrive together, the write is taken and the feed is dropped.
- R6: A select strobe carrying this controller's number `DEV_ID` (default 3) selects the controller and returns the cursor to row 0, column 0, whatever its previous position.
- R7: A select strobe carrying any other number deselects the controller. After that, writes and feeds change neither the levels nor the cursor. A select strobe takes priority over a write or feed in the same cycle.
- R8: A 4-bit counter advances once per clock. A lamp is lit in the cycles where the counter is below the lamp's level, so over any 16 consecutive cycles the lamp is lit for exactly `level` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_stb_i | input | 1 | Device select strobe |
| sel_dev_i | input | 8 | Device number sent with the select strobe |
| wr_stb_i | input | 1 | Data write strobe |
| wr_data_i | input | 8 | Data byte; the low nibble is the lamp level |
| feed_stb_i | input | 1 | Feed (new line) strobe |
| lamp_o | output | 25 | Lamp enables, bit `row*5 + col` |

## Verification
The stored levels can only be seen at the ports through the duty cycle of each lamp, never in a single sample. The bench therefore counts the lit cycles of all 25 lamps over 16 consecutive cycles and compares each count with the level it expects.

The hardest states to reach are the cursor wrapping from the bottom-right lamp and the re-home in the middle of a line. The stimulus reaches the wrap by writing a full 25-byte frame and then one more byte. It reaches the re-home by feeding down past row 4 and writing part of a line before selecting the controller again. It also selects another device and shows that a following write and feed leave all 25 duty counts unchanged.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FEED  = 2'd2,
    OP_HOME  = 2'd3
  } cur_op_e;
endpackage

// File: rtl/disp_decode.sv
module disp_decode
  import disp_pkg::*;
#(
  parameter int              DEV_W  = 8,
  parameter logic [DEV_W-1:0] DEV_ID = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_stb_i,
  input  logic [DEV_W-1:0] sel_dev_i,
  input  logic             wr_stb_i,
  input  logic             feed_stb_i,
  output logic             sel_o,
  output cur_op_e          op_o
);
  logic sel_q;
  logic hit;

  assign hit = (sel_dev_i == DEV_ID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sel_q <= 1'b0;
    else if (sel_stb_i) sel_q <= hit;
  end

  // select beats write, write beats feed
  always_comb begin
    op_o = OP_NONE;
    if (sel_stb_i) begin
      if (hit) op_o = OP_HOME;
    end else if (sel_q) begin
      if (wr_stb_i)        op_o = OP_WRITE;
      else if (feed_stb_i) op_o = OP_FEED;
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/disp_cursor.sv
module disp_cursor
  import disp_pkg::*;
#(
  parameter int ROWS  = 5,
  parameter int COLS  = 5,
  parameter int ROW_W = $clog2(ROWS),
  parameter int COL_W = $clog2(COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cur_op_e          op_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [ROW_W-1:0] row_q, row_nxt;
  logic [COL_W-1:0] col_q;

  assign row_nxt = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      unique case (op_i)
        OP_HOME: begin
          row_q <= '0;
          col_q <= '0;
        end
        OP_WRITE: begin
          if (col_q == COL_LAST) begin
            col_q <= '0;
            row_q <= row_nxt;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        OP_FEED: begin
          col_q <= '0;
          row_q <= row_nxt;
        end
        default: ;
      endcase
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;
endmodule

// File: rtl/disp_frame.sv
module disp_frame #(
  parameter int ROWS  = 5,
  parameter int COLS  = 5,
  parameter int LVL_W = 4,
  parameter int ROW_W = $clog2(ROWS),
  parameter int COL_W = $clog2(COLS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ROW_W-1:0]            row_i,
  input  logic [COL_W-1:0]            col_i,
  input  logic [LVL_W-1:0]            lvl_i,
  output logic [ROWS*COLS*LVL_W-1:0]  lvl_o
);
  localparam int N = ROWS * COLS;

  int wr_idx;
  assign wr_idx = int'(row_i) * COLS + int'(col_i);

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic [LVL_W-1:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cell_q <= '0;
      else if (we_i && wr_idx == i) cell_q <= lvl_i;
    end
    assign lvl_o[i*LVL_W +: LVL_W] = cell_q;
  end
endmodule

// File: rtl/disp_pwm.sv
module disp_pwm #(
  parameter int N     = 25,
  parameter int LVL_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N*LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0]   cnt_o,
  output logic [N-1:0]       lamp_o
);
  logic [LVL_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign lamp_o[i] = (cnt_q < lvl_i[i*LVL_W +: LVL_W]);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/matrix_display_ctrl.sv
module matrix_display_ctrl
  import disp_pkg::*;
#(
  parameter int               ROWS   = 5,
  parameter int               COLS   = 5,
  parameter int               LVL_W  = 4,
  parameter int               DATA_W = 8,
  parameter int               DEV_W  = 8,
  parameter logic [DEV_W-1:0] DEV_ID = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_stb_i,
  input  logic [DEV_W-1:0]     sel_dev_i,
  input  logic                 wr_stb_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 feed_stb_i,
  output logic [ROWS*COLS-1:0] lamp_o
);
  localparam int N     = ROWS * COLS;
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  cur_op_e                op;
  logic                   sel_q;
  logic [ROW_W-1:0]       row_q;
  logic [COL_W-1:0]       col_q;
  logic [LVL_W-1:0]       cnt_q;
  logic [N*LVL_W-1:0]     lvl_flat;
  logic                   unused_hi;

  assign unused_hi = ^wr_data_i[DATA_W-1:LVL_W];

  disp_decode #(.DEV_W(DEV_W), .DEV_ID(DEV_ID)) u_decode (
    .clk_i, .rst_ni, .sel_stb_i, .sel_dev_i, .wr_stb_i, .feed_stb_i,
    .sel_o(sel_q), .op_o(op)
  );

  disp_cursor #(.ROWS(ROWS), .COLS(COLS)) u_cursor (
    .clk_i, .rst_ni, .op_i(op), .row_o(row_q), .col_o(col_q)
  );

  disp_frame #(.ROWS(ROWS), .COLS(COLS), .LVL_W(LVL_W)) u_frame (
    .clk_i, .rst_ni,
    .we_i  (op == OP_WRITE),
    .row_i (row_q),
    .col_i (col_q),
    .lvl_i (wr_data_i[LVL_W-1:0]),
    .lvl_o (lvl_flat)
  );

  disp_pwm #(.N(N), .LVL_W(LVL_W)) u_pwm (
    .clk_i, .rst_ni, .lvl_i(lvl_flat), .cnt_o(cnt_q), .lamp_o
  );
endmodule

// File: rtl/disp_checker.sv
module disp_checker #(
  parameter int               ROWS   = 5,
  parameter int               COLS   = 5,
  parameter int               LVL_W  = 4,
  parameter int               DEV_W  = 8,
  parameter logic [DEV_W-1:0] DEV_ID = 3,
  parameter int               ROW_W  = $clog2(ROWS),
  parameter int               COL_W  = $clog2(COLS)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sel_stb_i,
  input logic [DEV_W-1:0]           sel_dev_i,
  input logic                       wr_stb_i,
  input logic                       feed_stb_i,
  input logic                       sel_q,
  input logic [ROW_W-1:0]           row_q,
  input logic [COL_W-1:0]           col_q,
  input logic [LVL_W-1:0]           cnt_q,
  input logic [ROWS*COLS*LVL_W-1:0] lvl_flat,
  input logic [ROWS*COLS-1:0]       lamp_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [LVL_W-1:0] LVL_MAX  = '1;

  AST_CURSOR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_q <= ROW_LAST && col_q <= COL_LAST); // R3

  AST_COL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q && wr_stb_i && !sel_stb_i && col_q != COL_LAST
    |=> col_q == $past(col_q) + 1'b1 && row_q == $past(row_q)); // R3

  AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q && wr_stb_i && !sel_stb_i && row_q == ROW_LAST && col_q == COL_LAST
    |=> row_q == '0 && col_q == '0); // R4

  AST_FEED_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q && feed_stb_i && !wr_stb_i && !sel_stb_i
    |=> col_q == '0 && row_q != $past(row_q)); // R5

  AST_SEL_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_stb_i && sel_dev_i == DEV_ID |=> row_q == '0 && col_q == '0 && sel_q); // R6

  AST_UNSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_q && !sel_stb_i
    |=> $stable(row_q) && $stable(col_q) && $stable(lvl_flat)); // R7

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1); // R8

  for (genvar i = 0; i < ROWS * COLS; i++) begin : g_lamp
    AST_FULL_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_flat[i*LVL_W +: LVL_W] == LVL_MAX && cnt_q != LVL_MAX |-> lamp_o[i]); // R8
    AST_ZERO_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_flat[i*LVL_W +: LVL_W] == '0 |-> !lamp_o[i]); // R8
  end
endmodule

bind matrix_display_ctrl disp_checker #(
  .ROWS(ROWS), .COLS(COLS), .LVL_W(LVL_W), .DEV_W(DEV_W), .DEV_ID(DEV_ID)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_stb_i(sel_stb_i), .sel_dev_i(sel_dev_i),
  .wr_stb_i(wr_stb_i), .feed_stb_i(feed_stb_i), .sel_q(sel_q), .row_q(row_q),
  .col_q(col_q), .cnt_q(cnt_q), .lvl_flat(lvl_flat), .lamp_o(lamp_o)
);

// File: tb/matrix_display_ctrl_tb.sv
module matrix_display_ctrl_tb;
  localparam int         N      = 25;
  localparam logic [7:0] MY_DEV = 8'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_stb = 1'b0;
  logic [7:0] sel_dev = '0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       feed_stb = 1'b0;
  logic [N-1:0] lamp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  matrix_display_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_stb_i(sel_stb), .sel_dev_i(sel_dev),
    .wr_stb_i(wr_stb), .wr_data_i(wr_data), .feed_stb_i(feed_stb), .lamp_o(lamp)
  );

  // requirement model
  int  exp_lvl [N];
  int  m_row = 0, m_col = 0;
  bit  m_sel = 0;

  // scoreboard
  int    q_idx[$];
  int    q_lvl[$];
  string q_tag[$];
  event  go_ev, done_ev;

  function automatic void step_row();
    m_row = (m_row == 4) ? 0 : m_row + 1;
  endfunction

  task automatic do_sel(input logic [7:0] dev);
    @(negedge clk);
    sel_stb = 1'b1; sel_dev = dev;
    @(negedge clk);
    sel_stb = 1'b0;
    m_sel = (dev == MY_DEV);
    if (m_sel) begin m_row = 0; m_col = 0; end
  endtask

  task automatic do_wr(input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    if (m_sel) begin
      exp_lvl[m_row*5 + m_col] = int'(d[3:0]);
      if (m_col == 4) begin m_col = 0; step_row(); end
      else m_col++;
    end
  endtask

  task automatic do_feed();
    @(negedge clk);
    feed_stb = 1'b1;
    @(negedge clk);
    feed_stb = 1'b0;
    if (m_sel) begin m_col = 0; step_row(); end
  endtask

  task automatic check_frame(input string tag);
    for (int i = 0; i < N; i++) begin
      q_idx.push_back(i);
      q_lvl.push_back(exp_lvl[i]);
      q_tag.push_back(tag);
    end
    ->go_ev;
    @(done_ev);
  endtask

  // monitor: duty over 16 consecutive cycles equals level
  initial begin
    int lit [N];
    forever begin
      @(go_ev);
      for (int i = 0; i < N; i++) lit[i] = 0;
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        for (int i = 0; i < N; i++) lit[i] += int'(lamp[i]);
      end
      while (q_idx.size() > 0) begin
        int    ix, lv;
        string tg;
        ix = q_idx.pop_front();
        lv = q_lvl.pop_front();
        tg = q_tag.pop_front();
        checks++;
        if (lit[ix] != lv) begin
          errors++;
          $display("FAIL %s lamp %0d duty got %0d exp %0d", tg, ix, lit[ix], lv);
        end
      end
      ->done_ev;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) exp_lvl[i] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (lamp !== '0) begin
      errors++;
      $display("FAIL R1 lamps during reset got %h exp 0", lamp);
    end
    rst_n = 1'b1;
    check_frame("R1 reset levels");

    do_wr(8'hA5);
    do_feed();
    check_frame("R1 R7 write before select");

    do_sel(MY_DEV);
    for (int i = 0; i < N; i++) do_wr({4'(i), 4'((i * 7 + 3) % 16)});
    check_frame("R2 R3 full frame");

    do_wr(8'h3C);
    check_frame("R4 wrap to lamp 0");

    do_feed();
    do_wr(8'hF9);
    check_frame("R5 feed to row 1");

    do_wr(8'h01);
    do_wr(8'h02);
    do_wr(8'h04);
    do_wr(8'h06);
    do_wr(8'h07);
    do_wr(8'h08);
    check_frame("R3 row 1 to row 2");

    do_feed();
    do_feed();
    do_feed();
    do_wr(8'h5E);
    check_frame("R5 feed wraps row 4 to 0");

    do_sel(8'd5);
    do_wr(8'h0B);
    do_feed();
    do_wr(8'h0D);
    check_frame("R7 other device ignored");

    do_sel(MY_DEV);
    do_wr(8'h0F);
    do_wr(8'hF0);
    do_sel(MY_DEV);
    do_wr(8'h2A);
    check_frame("R6 reselect homes cursor");

    do_wr(8'h7F);
    do_wr(8'h80);
    do_wr(8'h3F);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = 8'h09; feed_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; feed_stb = 1'b0;
    exp_lvl[4] = 9; m_col = 0; step_row();
    do_wr(8'h0C);
    check_frame("R8 R5 extremes and write over feed");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule